// File: doc/BRIEF.md
# Ethernet Receive Destination Address Filter

This block decides, for each received frame, whether its 48-bit destination address lets the frame through. The receiver streams the six destination-address bytes into the block, first byte first, each qualified by a valid strobe, and marks the start of every frame with a one-cycle start pulse. Configuration comes in as static inputs: a station address split over a 32-bit low word and a 16-bit high word, a 64-bit multicast hash table split over two 32-bit words, and a mode word.

Unicast addresses are compared with the station address. The all-ones address is broadcast and is gated by a mode bit. Any other address with bit 0 of its first byte set is multicast: the block runs the Ethernet CRC-32 over the six bytes and uses the top six bits of the result to pick one bit of the hash table. A promiscuous mode bit accepts every frame. One clock after the sixth byte, the block raises a one-cycle done strobe together with its accept decision.

Top module: `addr_filter`

## Requirements
- R1: After reset, done_o and accept_o are both 0, and accept_o is never 1 unless done_o is 1.
- R2: done_o is high for exactly one cycle, in the cycle after the sixth valid byte of a frame is sampled. Further valid bytes before the next start pulse produce no further done_o.
- R3: A unicast address (bit 0 of byte 0 clear) is accepted when its bytes 0..5 equal, in order, station_hi_i[15:8], station_hi_i[7:0], station_lo_i[31:24], station_lo_i[23:16], station_lo_i[15:8], station_lo_i[7:0].
- R4: A unicast address that differs from the station address in any byte is rejected when promiscuous mode is off.
- R5: The address FF:FF:FF:FF:FF:FF is broadcast and is never hashed. It is accepted when mode_i bit 3 is 0 and rejected when mode_i bit 3 is 1.
- R6: For a multicast address other than broadcast, the CRC-32 (polynomial 0x04C11DB7, seed all ones, each byte taken LSB first, no final inversion) is computed over the six bytes; index = CRC bits 31:26. The frame is accepted when bit index[4:0] of hash_hi_i (index[5] = 1) or of hash_lo_i (index[5] = 0) is 1, and rejected otherwise.
- R7: With both hash words all ones, every multicast address is accepted.
- R8: When mode_i bit 5 is 1, every frame is accepted regardless of address or of mode_i bit 3.
- R9: A start pulse discards the bytes of an unfinished frame and reseeds the CRC and comparison state. A byte presented in the same cycle as the start pulse counts as the first byte of the new frame.
- R10: Cycles with byte_valid_i low between address bytes are ignored; only valid cycles advance the byte position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sof_i | input | 1 | Frame start pulse |
| byte_valid_i | input | 1 | Qualifies byte_i |
| byte_i | input | 8 | Destination-address byte, first byte first |
| station_lo_i | input | 32 | Station address bytes 2..5 |
| station_hi_i | input | 16 | Station address bytes 0..1 |
| hash_lo_i | input | 32 | Hash table bits for index 0..31 |
| hash_hi_i | input | 32 | Hash table bits for index 32..63 |
| mode_i | input | 16 | Bit 3 blocks broadcast, bit 5 promiscuous |
| done_o | output | 1 | One-cycle strobe after the sixth byte |
| accept_o | output | 1 | Decision, valid while done_o is high |

## Verification
Directed frames separate the four decision paths: the exact station address against the same address with its first or last byte altered, broadcast with the blocking bit clear and set, and a multicast address against a hash table holding only its own bit and against the inverse table, which shows that both the index and the word selection are right. Promiscuous runs use addresses that every other path would reject. Frames with idle gaps, a frame cut short by a start pulse that carries the next first byte, and trailing bytes after the sixth check the byte counting. Random addresses, with byte 0 forced unicast or multicast and mixed with random station, hash and mode settings, are then compared against a bench model of the whole decision.

// File: rtl/addr_filter_pkg.sv
package addr_filter_pkg;
  localparam int          ADDR_BYTES = 6;
  localparam int          CRC_W      = 32;
  localparam int          HASH_IDX_W = 6;
  localparam logic [31:0] CRC_POLY   = 32'h04C11DB7;

  typedef enum logic [1:0] {
    DEC_UNICAST = 2'd0,
    DEC_BCAST   = 2'd1,
    DEC_MCAST   = 2'd2
  } dec_kind_e;

  // one byte, LSB first, MSB-shifting register
  function automatic logic [CRC_W-1:0] crc_byte(input logic [CRC_W-1:0] c_in,
                                                input logic [7:0] d);
    logic [CRC_W-1:0] c;
    logic fb;
    c = c_in;
    for (int b = 0; b < 8; b++) begin
      fb = c[CRC_W-1] ^ d[b];
      c  = {c[CRC_W-2:0], 1'b0};
      if (fb) c = c ^ CRC_POLY;
    end
    return c;
  endfunction
endpackage

// File: rtl/af_byte_counter.sv
module af_byte_counter #(
  parameter int N  = 6,
  localparam int CW = $clog2(N + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sof_i,
  input  logic          valid_i,
  output logic [CW-1:0] idx_o,
  output logic          take_o,
  output logic          last_o
);
  logic [CW-1:0] cnt_q, cnt_cur;

  assign cnt_cur = sof_i ? '0 : cnt_q;
  assign idx_o   = cnt_cur;
  assign take_o  = valid_i && (cnt_cur < CW'(N));
  assign last_o  = take_o && (cnt_cur == CW'(N - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (take_o) cnt_q <= cnt_cur + CW'(1);
    else             cnt_q <= cnt_cur;
  end

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(N)); // R2

  AST_CNT_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sof_i && !valid_i |=> $stable(cnt_q)); // R10
endmodule

// File: rtl/af_crc_unit.sv
module af_crc_unit
  import addr_filter_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sof_i,
  input  logic             take_i,
  input  logic [7:0]       byte_i,
  output logic [CRC_W-1:0] crc_nxt_o
);
  logic [CRC_W-1:0] crc_q, crc_cur;

  assign crc_cur   = sof_i ? '1 : crc_q;
  assign crc_nxt_o = take_i ? crc_byte(crc_cur, byte_i) : crc_cur;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) crc_q <= '1;
    else         crc_q <= crc_nxt_o;
  end

  AST_CRC_RESEED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_i && !take_i |=> crc_q == '1); // R9
endmodule

// File: rtl/af_station_cmp.sv
module af_station_cmp #(
  parameter int N  = 6,
  localparam int CW = $clog2(N + 1),
  localparam int AW = 8 * N
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sof_i,
  input  logic          take_i,
  input  logic [CW-1:0] idx_i,
  input  logic [7:0]    byte_i,
  input  logic [AW-1:0] station_i,
  output logic          eq_nxt_o,
  output logic          ones_nxt_o,
  output logic          grp_nxt_o
);
  logic [7:0] exp_b [N];
  logic [7:0] exp_cur;
  logic eq_q, ones_q, grp_q;
  logic eq_cur, ones_cur, grp_cur;

  // byte 0 is the most significant byte of the packed station address
  for (genvar k = 0; k < N; k++) begin : g_exp
    assign exp_b[k] = station_i[AW-1-8*k -: 8];
  end

  always_comb begin
    exp_cur = '0;
    for (int k = 0; k < N; k++)
      if (idx_i == CW'(k)) exp_cur = exp_b[k];
  end

  assign eq_cur   = sof_i ? 1'b1 : eq_q;
  assign ones_cur = sof_i ? 1'b1 : ones_q;
  assign grp_cur  = sof_i ? 1'b0 : grp_q;

  always_comb begin
    eq_nxt_o   = eq_cur;
    ones_nxt_o = ones_cur;
    grp_nxt_o  = grp_cur;
    if (take_i) begin
      eq_nxt_o   = eq_cur & (byte_i == exp_cur);
      ones_nxt_o = ones_cur & (byte_i == 8'hFF);
      if (idx_i == '0) grp_nxt_o = byte_i[0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eq_q   <= 1'b1;
      ones_q <= 1'b1;
      grp_q  <= 1'b0;
    end else begin
      eq_q   <= eq_nxt_o;
      ones_q <= ones_nxt_o;
      grp_q  <= grp_nxt_o;
    end
  end

  AST_ONES_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sof_i && !ones_q |=> !ones_q); // R5

  AST_EQ_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sof_i && !eq_q |=> !eq_q); // R4
endmodule

// File: rtl/addr_filter.sv
module addr_filter
  import addr_filter_pkg::*;
#(
  parameter int MODE_W      = 16,
  parameter int BCAST_OFF_B = 3,
  parameter int PROMISC_B   = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sof_i,
  input  logic              byte_valid_i,
  input  logic [7:0]        byte_i,
  input  logic [31:0]       station_lo_i,
  input  logic [15:0]       station_hi_i,
  input  logic [31:0]       hash_lo_i,
  input  logic [31:0]       hash_hi_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic              done_o,
  output logic              accept_o
);
  localparam int CW = $clog2(ADDR_BYTES + 1);

  logic [CW-1:0]         idx;
  logic                  take, last;
  logic [CRC_W-1:0]      crc_nxt;
  logic                  eq_nxt, ones_nxt, grp_nxt;
  logic [HASH_IDX_W-1:0] hidx;
  logic                  hash_hit, decide;
  dec_kind_e             kind;
  logic                  done_q, accept_q;

  af_byte_counter #(.N(ADDR_BYTES)) u_cnt (
    .clk_i, .rst_ni, .sof_i,
    .valid_i (byte_valid_i),
    .idx_o   (idx),
    .take_o  (take),
    .last_o  (last)
  );

  af_crc_unit u_crc (
    .clk_i, .rst_ni, .sof_i,
    .take_i    (take),
    .byte_i,
    .crc_nxt_o (crc_nxt)
  );

  af_station_cmp #(.N(ADDR_BYTES)) u_cmp (
    .clk_i, .rst_ni, .sof_i,
    .take_i     (take),
    .idx_i      (idx),
    .byte_i,
    .station_i  ({station_hi_i, station_lo_i}),
    .eq_nxt_o   (eq_nxt),
    .ones_nxt_o (ones_nxt),
    .grp_nxt_o  (grp_nxt)
  );

  assign hidx     = crc_nxt[CRC_W-1 -: HASH_IDX_W];
  assign hash_hit = hidx[HASH_IDX_W-1] ? hash_hi_i[hidx[4:0]] : hash_lo_i[hidx[4:0]];

  always_comb begin
    if (ones_nxt)     kind = DEC_BCAST;
    else if (grp_nxt) kind = DEC_MCAST;
    else              kind = DEC_UNICAST;
  end

  always_comb begin
    unique case (kind)
      DEC_BCAST: decide = !mode_i[BCAST_OFF_B];
      DEC_MCAST: decide = hash_hit;
      default:   decide = eq_nxt;
    endcase
    if (mode_i[PROMISC_B]) decide = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q   <= 1'b0;
      accept_q <= 1'b0;
    end else begin
      done_q   <= last;
      accept_q <= last & decide;
    end
  end

  assign done_o   = done_q;
  assign accept_o = accept_q;

  AST_ACCEPT_QUAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> done_o); // R1

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R2

  AST_DONE_AFTER_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(byte_valid_i)); // R2

  AST_PROMISC_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last && mode_i[PROMISC_B] |=> accept_o); // R8

  AST_BCAST_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last && ones_nxt && mode_i[BCAST_OFF_B] && !mode_i[PROMISC_B] |=> !accept_o); // R5
endmodule

// File: tb/sim_addr_filter.sv
`timescale 1ns/1ps
module sim_addr_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sof = 1'b0;
  logic        valid = 1'b0;
  logic [7:0]  bdat = '0;
  logic [31:0] st_lo = '0;
  logic [15:0] st_hi = '0;
  logic [31:0] h_lo = '0;
  logic [31:0] h_hi = '0;
  logic [15:0] mode = '0;
  logic        done, acc;

  int checks = 0;
  int errors = 0;
  bit ended = 1'b0;

  always #10 clk = ~clk;

  addr_filter u0 (
    .clk_i (clk), .rst_ni (rst_n), .sof_i (sof), .byte_valid_i (valid),
    .byte_i (bdat), .station_lo_i (st_lo), .station_hi_i (st_hi),
    .hash_lo_i (h_lo), .hash_hi_i (h_hi), .mode_i (mode),
    .done_o (done), .accept_o (acc)
  );

  function automatic logic [31:0] ref_crc(input logic [47:0] a);
    logic [31:0] c;
    logic [7:0] d;
    logic fb;
    c = '1;
    for (int i = 0; i < 6; i++) begin
      d = a[47-8*i -: 8];
      for (int b = 0; b < 8; b++) begin
        fb = c[31] ^ d[b];
        c = {c[30:0], 1'b0};
        if (fb) c = c ^ 32'h04C11DB7;
      end
    end
    return c;
  endfunction

  function automatic logic [5:0] ref_idx(input logic [47:0] a);
    logic [31:0] c;
    c = ref_crc(a);
    return c[31:26];
  endfunction

  function automatic logic ref_accept(input logic [47:0] a);
    logic [5:0] ix;
    if (mode[5]) return 1'b1;
    if (a == 48'hFFFF_FFFF_FFFF) return !mode[3];
    if (a[40]) begin
      ix = ref_idx(a);
      return ix[5] ? h_hi[ix[4:0]] : h_lo[ix[4:0]];
    end
    return a == {st_hi, st_lo};
  endfunction

  task automatic check(input logic got, input logic exp, input string req, input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %b expected %b", req, what, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // sends the six bytes; checks done/accept one clock after the last
  task automatic run_frame(input logic [47:0] a, input bit gaps, input bit sof_first,
                           input string req);
    logic e;
    e = ref_accept(a);
    if (!sof_first) begin
      @(negedge clk); sof = 1'b1; valid = 1'b0;
      @(negedge clk); sof = 1'b0;
    end
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      sof   = sof_first && (k == 0);
      valid = 1'b1;
      bdat  = a[47-8*k -: 8];
      if (gaps && k < 5) begin
        @(negedge clk); sof = 1'b0; valid = 1'b0;
        check(done, 1'b0, req, "done during gap");
      end
    end
    @(negedge clk); sof = 1'b0; valid = 1'b0;
    check(done, 1'b1, req, "done after sixth byte");
    check(acc, e, req, "accept");
    @(negedge clk);
    check(done, 1'b0, "R2", "done width");
  endtask

  task automatic partial(input logic [47:0] a, input int n);
    @(negedge clk); sof = 1'b1; valid = 1'b0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk); sof = 1'b0; valid = 1'b1; bdat = a[47-8*k -: 8];
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [47:0] a;
    logic [5:0] ix;
    logic [63:0] hv;
    int seed;
    seed = $urandom(1234);
    repeat (3) @(negedge clk);
    check(done, 1'b0, "R1", "reset done");
    check(acc, 1'b0, "R1", "reset accept");
    rst_n = 1'b1;
    st_hi = 16'h0211; st_lo = 32'h2233_4455;

    run_frame(48'h0211_2233_4455, 1'b0, 1'b0, "R3");
    run_frame(48'h0211_2233_4456, 1'b0, 1'b0, "R4");
    run_frame(48'h0A11_2233_4455, 1'b0, 1'b0, "R4");

    mode = 16'h0000; run_frame(48'hFFFF_FFFF_FFFF, 1'b0, 1'b0, "R5");
    mode = 16'h0008; run_frame(48'hFFFF_FFFF_FFFF, 1'b0, 1'b0, "R5");
    check(acc, 1'b0, "R5", "blocked broadcast stays low");

    a  = 48'h0100_5E00_0001;
    ix = ref_idx(a);
    hv = 64'd1 << ix;
    {h_hi, h_lo} = hv;  run_frame(a, 1'b0, 1'b0, "R6");
    {h_hi, h_lo} = ~hv; run_frame(a, 1'b0, 1'b0, "R6");
    a  = 48'h3333_0000_00FB;
    hv = 64'd1 << ref_idx(a);
    {h_hi, h_lo} = hv;  run_frame(a, 1'b0, 1'b0, "R6");

    {h_hi, h_lo} = '1;
    for (int i = 0; i < 8; i++) begin
      a = {$urandom(), $urandom()};
      a[40] = 1'b1;
      if (a == 48'hFFFF_FFFF_FFFF) a[0] = 1'b0;
      run_frame(a, 1'b0, 1'b0, "R7");
    end
    {h_hi, h_lo} = '0;

    mode = 16'h0028;
    run_frame(48'h0011_2233_4455, 1'b0, 1'b0, "R8");
    run_frame(48'hFFFF_FFFF_FFFF, 1'b0, 1'b0, "R8");
    run_frame(48'h0100_5E00_0001, 1'b0, 1'b0, "R8");
    mode = 16'h0000;

    run_frame(48'h0211_2233_4455, 1'b1, 1'b0, "R10");

    partial(48'h0A0B_0C0D_0E0F, 3);
    run_frame(48'h0211_2233_4455, 1'b0, 1'b1, "R9");
    partial(48'h0211_2233_0000, 4);
    run_frame(48'h0211_2233_4455, 1'b0, 1'b0, "R9");

    for (int k = 0; k < 3; k++) begin
      @(negedge clk); valid = 1'b1; bdat = 8'h55;
      @(negedge clk); valid = 1'b0;
      check(done, 1'b0, "R2", "trailing byte ignored");
    end

    for (int i = 0; i < 300; i++) begin
      st_hi = 16'($urandom()); st_lo = $urandom();
      st_hi[8] = 1'b0;
      h_lo = $urandom(); h_hi = $urandom();
      mode = 16'($urandom()) & 16'h0028;
      case ($urandom() % 4)
        0: a = {st_hi, st_lo};
        1: a = 48'hFFFF_FFFF_FFFF;
        default: a = {$urandom(), $urandom()};
      endcase
      run_frame(a, ($urandom() % 4) == 0, 1'b0,
                a == 48'hFFFF_FFFF_FFFF ? "R5" : (a[40] ? "R6" : "R3"));
    end

    finish_run();
  end
endmodule